// File: doc/BRIEF.md
# SDRAM Power-Up Init Sequencer

This block brings a single-rank, 32-bit-wide SDR SDRAM from power-on to a usable state. After reset it enables the clock and holds the command bus idle for a stabilisation period. It then closes every bank, runs a short train of closely spaced auto-refresh cycles, and writes the mode register. When that is done it reports that initialisation is complete.

From then on it acts only as a refresh timer. At a fixed interval it raises a refresh request, which the memory controller downstream services and acknowledges.

Every delay is a parameter. The stabilisation wait is derived from a clock-rate parameter in kHz and a wait length in microseconds, so a bench can shrink it without touching the other timings. The defaults suit a 60 MHz memory clock and a part with 4 banks, 12 row bits and 9 column bits. The mode register is written for sequential bursts of 4 at CAS latency 2. At elaboration the block rejects a refresh interval longer than 15.625 µs, which is 64 ms spread over 4096 rows.

Top module: `sdram_pwrup_seq`

## Requirements
- R1: While `rst` is high, `cke` is 0, the command pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 0111), and `init_done` and `ref_req` are both 0.
- R2: Counting clock edges from reset release (the first edge is cycle 1), `cke` is 1 from cycle 1 onward and stays 1. Cycles 1 to W-1 carry NOP, where W = CLK_KHZ*WAIT_US/1000.
- R3: In cycle W the block issues a single precharge-all (pins 0010), with address bit 10 set and every other address bit 0. The following cycle is NOP.
- R4: A fast-refresh phase starts T_RP cycles after the precharge and lasts FAST_HOLD cycles. Inside it, an auto-refresh (pins 0001) is issued in each phase cycle k, counted from 0, where (k+1) is a multiple of FAST_DIV*16. Every other cycle is NOP. With the defaults this gives 4 refreshes, 32 cycles apart.
- R5: A mode-register write (pins 0000) is issued T_RFC cycles after the last cycle of the fast phase. Its address is CAS_LAT in bits 6:4, 0 in bit 3 (sequential burst) and log2(BURST_LEN) in bits 2:0, which is 0x22 by default. The bank bits are 0.
- R6: `init_done` rises T_MRD cycles after the mode-register write and never falls afterwards. From then on the command pins carry only NOP.
- R7: `ref_req` rises NORM_DIV*16 cycles after `init_done` rises. It stays high until `ref_ack` is sampled high at a clock edge, and it is low in the cycle after that edge.
- R8: Refresh requests recur every NORM_DIV*16 cycles whenever the acknowledge arrives. If an acknowledge is sampled at the same edge that a new interval expires, `ref_req` stays high.
- R9: `ref_ack` has no effect while no request is pending. During initialisation it neither shifts the command sequence nor raises `ref_req`. After initialisation it neither raises `ref_req` nor moves the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Asynchronous active-high reset |
| ref_ack | input | 1 | Controller acknowledges the pending refresh request |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ROW_W | Address bus (mode word or precharge-all flag) |
| init_done | output | 1 | Initialisation complete |
| ref_req | output | 1 | Periodic refresh request, held until acknowledged |

## Verification
The command sequence is compared cycle by cycle against a schedule computed from the parameters. A refresh one cycle early or late, a lost refresh, or a stretched gap therefore shows up as a wrong command in a specific cycle, not only as a wrong total. The acknowledge input is exercised four ways:
- held high during start-up, which separates a sequencer that ignores it from one that lets it disturb the sequence;
- pulsed while a request is pending, which checks that the request clears;
- pulsed with nothing pending, which checks that the timer phase is not moved;
- landed on the very edge a new interval expires, which separates "new request wins" from "acknowledge wins".

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

   typedef enum logic [2:0] {
      PH_STABLE,
      PH_PALL,
      PH_GAP_RP,
      PH_FAST,
      PH_GAP_RFC,
      PH_MODE,
      PH_GAP_MRD,
      PH_RUN
   } init_phase_e;

   typedef enum logic [1:0] {
      OP_NOP,
      OP_PALL,
      OP_AREF,
      OP_MODE
   } sd_op_e;

   // {cs_n, ras_n, cas_n, we_n}
   typedef logic [3:0] sd_pins_t;
   localparam sd_pins_t PINS_NOP  = 4'b0111;
   localparam sd_pins_t PINS_PALL = 4'b0010;
   localparam sd_pins_t PINS_AREF = 4'b0001;
   localparam sd_pins_t PINS_MODE = 4'b0000;

   localparam int PALL_ADDR_BIT = 10;

   function automatic int bits_for(input longint unsigned v);
      int w;
      w = $clog2(v + 1);
      return (w < 1) ? 1 : w;
   endfunction

   function automatic longint unsigned max_u(input longint unsigned a,
                                             input longint unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
   parameter int FAST_IVL = 32,
   parameter int NORM_IVL = 928
) (
   input  logic clk,
   input  logic rst,
   input  logic en,
   input  logic fast_sel,
   output logic tick
);
   localparam int CW = sdram_init_pkg::bits_for(
                          sdram_init_pkg::max_u(FAST_IVL, NORM_IVL));

   logic [CW-1:0] cnt;
   logic [CW-1:0] last_cnt;

   assign last_cnt = fast_sel ? CW'(FAST_IVL - 1) : CW'(NORM_IVL - 1);
   assign tick     = en && (cnt == last_cnt);

   always_ff @(posedge clk or posedge rst) begin
      if (rst)              cnt <= '0;
      else if (!en || tick) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
   import sdram_init_pkg::*;
#(
   parameter longint unsigned WAIT_CYC  = 12000000,
   parameter int              T_RP      = 2,
   parameter int              T_RFC     = 5,
   parameter int              T_MRD     = 2,
   parameter int              FAST_HOLD = 128
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   tick,
   output sd_op_e op,
   output logic   done,
   output logic   timer_en,
   output logic   timer_fast
);
   localparam longint unsigned MAX_T =
      max_u(max_u(WAIT_CYC, FAST_HOLD), max_u(max_u(T_RP, T_RFC), T_MRD));
   localparam int CNT_W = bits_for(MAX_T);

   init_phase_e      phase;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         phase <= PH_STABLE;
         cnt   <= CNT_W'(WAIT_CYC - 1);
      end else begin
         unique case (phase)
            PH_STABLE:
               if (cnt == '0) phase <= PH_PALL;
               else           cnt   <= cnt - 1'b1;
            PH_PALL: begin
               phase <= PH_GAP_RP;
               cnt   <= CNT_W'(T_RP - 2);
            end
            PH_GAP_RP:
               if (cnt == '0) begin
                  phase <= PH_FAST;
                  cnt   <= CNT_W'(FAST_HOLD - 1);
               end else cnt <= cnt - 1'b1;
            PH_FAST:
               if (cnt == '0) begin
                  phase <= PH_GAP_RFC;
                  cnt   <= CNT_W'(T_RFC - 2);
               end else cnt <= cnt - 1'b1;
            PH_GAP_RFC:
               if (cnt == '0) phase <= PH_MODE;
               else           cnt   <= cnt - 1'b1;
            PH_MODE: begin
               phase <= PH_GAP_MRD;
               cnt   <= CNT_W'(T_MRD - 2);
            end
            PH_GAP_MRD:
               if (cnt == '0) phase <= PH_RUN;
               else           cnt   <= cnt - 1'b1;
            PH_RUN: phase <= PH_RUN;
            default: phase <= PH_STABLE;
         endcase
      end
   end

   always_comb begin
      unique case (phase)
         PH_PALL: op = OP_PALL;
         PH_MODE: op = OP_MODE;
         PH_FAST: op = tick ? OP_AREF : OP_NOP;
         default: op = OP_NOP;
      endcase
   end

   assign done       = (phase == PH_RUN);
   assign timer_fast = (phase == PH_FAST);
   assign timer_en   = (phase == PH_FAST) || (phase == PH_RUN);

endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
   import sdram_init_pkg::*;
#(
   parameter int ROW_W     = 12,
   parameter int BANK_W    = 2,
   parameter int MODE_WORD = 'h22
) (
   input  sd_op_e            op,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr
);
   sd_pins_t pins;

   always_comb begin
      ba   = '0;
      addr = '0;
      unique case (op)
         OP_PALL: begin
            pins                = PINS_PALL;
            addr[PALL_ADDR_BIT] = 1'b1;
         end
         OP_AREF: pins = PINS_AREF;
         OP_MODE: begin
            pins = PINS_MODE;
            addr = ROW_W'(MODE_WORD);
         end
         default: pins = PINS_NOP;
      endcase
   end

   assign {cs_n, ras_n, cas_n, we_n} = pins;

endmodule

// File: rtl/sdram_pwrup_seq.sv
module sdram_pwrup_seq
   import sdram_init_pkg::*;
#(
   parameter int CLK_KHZ   = 60000,
   parameter int WAIT_US   = 200000,
   parameter int ROW_W     = 12,
   parameter int COL_W     = 9,
   parameter int BANK_W    = 2,
   parameter int BURST_LEN = 4,
   parameter int CAS_LAT   = 2,
   parameter int T_RP      = 2,
   parameter int T_RFC     = 5,
   parameter int T_MRD     = 2,
   parameter int REF_UNIT  = 16,
   parameter int FAST_DIV  = 2,
   parameter int FAST_HOLD = 128,
   parameter int NORM_DIV  = 58
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ref_ack,
   output logic              cke,
   output logic              cs_n,
   output logic              ras_n,
   output logic              cas_n,
   output logic              we_n,
   output logic [BANK_W-1:0] ba,
   output logic [ROW_W-1:0]  addr,
   output logic              init_done,
   output logic              ref_req
);
   localparam longint unsigned WAIT_CYC =
      longint'(CLK_KHZ) * longint'(WAIT_US) / 1000;
   localparam int FAST_IVL  = FAST_DIV * REF_UNIT;
   localparam int NORM_IVL  = NORM_DIV * REF_UNIT;
   localparam int MODE_WORD = (CAS_LAT << 4) | $clog2(BURST_LEN);
   localparam longint unsigned IVL_SCALED = longint'(NORM_IVL) * 1000000;
   localparam longint unsigned IVL_LIMIT  = longint'(CLK_KHZ) * 15625;

   generate
      if (WAIT_CYC < 1) begin : g_bad_wait
         $error("stabilisation wait must be at least one cycle");
      end
      if (T_RP < 2 || T_RFC < 2 || T_MRD < 2) begin : g_bad_gap
         $error("command gaps must be at least two cycles");
      end
      if (FAST_IVL < T_RFC || FAST_HOLD < FAST_IVL) begin : g_bad_fast
         $error("fast refresh spacing or hold window is inconsistent");
      end
      if (IVL_SCALED > IVL_LIMIT) begin : g_bad_refi
         $error("refresh interval exceeds 15.625 us");
      end
      if (BURST_LEN != 1 && BURST_LEN != 2 && BURST_LEN != 4 && BURST_LEN != 8)
      begin : g_bad_bl
         $error("burst length must be 1, 2, 4 or 8");
      end
      if (CAS_LAT < 1 || CAS_LAT > 3) begin : g_bad_cl
         $error("CAS latency must be 1 to 3");
      end
      if (ROW_W <= PALL_ADDR_BIT || COL_W >= ROW_W || BANK_W < 1)
      begin : g_bad_geom
         $error("address geometry is inconsistent");
      end
   endgenerate

   sd_op_e op;
   logic   tick;
   logic   timer_en;
   logic   timer_fast;
   logic   done_w;

   sdram_init_fsm #(
      .WAIT_CYC  (WAIT_CYC),
      .T_RP      (T_RP),
      .T_RFC     (T_RFC),
      .T_MRD     (T_MRD),
      .FAST_HOLD (FAST_HOLD)
   ) fsm_i (
      .clk        (clk),
      .rst        (rst),
      .tick       (tick),
      .op         (op),
      .done       (done_w),
      .timer_en   (timer_en),
      .timer_fast (timer_fast)
   );

   sdram_ref_timer #(
      .FAST_IVL (FAST_IVL),
      .NORM_IVL (NORM_IVL)
   ) timer_i (
      .clk      (clk),
      .rst      (rst),
      .en       (timer_en),
      .fast_sel (timer_fast),
      .tick     (tick)
   );

   sdram_cmd_drive #(
      .ROW_W     (ROW_W),
      .BANK_W    (BANK_W),
      .MODE_WORD (MODE_WORD)
   ) drive_i (
      .op    (op),
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .ba    (ba),
      .addr  (addr)
   );

   always_ff @(posedge clk or posedge rst) begin
      if (rst) begin
         cke     <= 1'b0;
         ref_req <= 1'b0;
      end else begin
         cke     <= 1'b1;
         ref_req <= (done_w && tick) || (ref_req && !ref_ack);
      end
   end

   assign init_done = done_w;

endmodule

// File: rtl/sdram_pwrup_seq_chk.sv
module sdram_pwrup_seq_chk #(
   parameter int ROW_W     = 12,
   parameter int BANK_W    = 2,
   parameter int MODE_WORD = 'h22
) (
   input logic              clk,
   input logic              rst,
   input logic              ref_ack,
   input logic              cke,
   input logic              cs_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              we_n,
   input logic [BANK_W-1:0] ba,
   input logic [ROW_W-1:0]  addr,
   input logic              init_done,
   input logic              ref_req
);
   logic [3:0] pins;
   assign pins = {cs_n, ras_n, cas_n, we_n};

   assert_nop_while_cke_low_R1: assert property (@(posedge clk) disable iff (rst)
      !cke |-> pins == 4'b0111);

   assert_cke_stays_high_R2: assert property (@(posedge clk) disable iff (rst)
      $past(cke) |-> cke);

   assert_pall_flag_R3: assert property (@(posedge clk) disable iff (rst)
      pins == 4'b0010 |-> addr == (ROW_W'(1) << 10) && !init_done);

   assert_aref_only_in_init_R4: assert property (@(posedge clk) disable iff (rst)
      pins == 4'b0001 |-> cke && !init_done);

   assert_mode_word_R5: assert property (@(posedge clk) disable iff (rst)
      pins == 4'b0000 |-> addr == ROW_W'(MODE_WORD) && ba == '0 && !init_done);

   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (rst)
      init_done |=> init_done);

   assert_quiet_after_done_R6: assert property (@(posedge clk) disable iff (rst)
      init_done |-> pins == 4'b0111);

   assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
      ref_req && !ref_ack |=> ref_req);

   assert_no_req_in_init_R9: assert property (@(posedge clk) disable iff (rst)
      !init_done |-> !ref_req);

endmodule

bind sdram_pwrup_seq sdram_pwrup_seq_chk #(
   .ROW_W     (ROW_W),
   .BANK_W    (BANK_W),
   .MODE_WORD (MODE_WORD)
) chk_i (.*);

// File: tb/sdram_pwrup_seq_tb_top.sv
module sdram_pwrup_seq_tb_top;
   localparam int CLK_PERIOD = 10;

   localparam int CLK_KHZ   = 60000;
   localparam int WAIT_US   = 1;
   localparam int ROW_W     = 12;
   localparam int BANK_W    = 2;
   localparam int T_RP      = 2;
   localparam int T_RFC     = 5;
   localparam int T_MRD     = 2;
   localparam int FAST_HOLD = 128;
   localparam int FAST_IVL  = 2 * 16;
   localparam int NORM_IVL  = 58 * 16;

   // schedule from the requirements
   localparam int W       = CLK_KHZ * WAIT_US / 1000;
   localparam int F0      = W + T_RP;
   localparam int MODE_AT = F0 + FAST_HOLD + T_RFC - 1;
   localparam int D       = MODE_AT + T_MRD;
   localparam int N       = NORM_IVL;
   localparam int EXP_MODE = (2 << 4) | 2;

   localparam logic [3:0] P_NOP  = 4'b0111;
   localparam logic [3:0] P_PALL = 4'b0010;
   localparam logic [3:0] P_AREF = 4'b0001;
   localparam logic [3:0] P_MODE = 4'b0000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic              ref_ack = 1'b0;
   logic              cke, cs_n, ras_n, cas_n, we_n;
   logic [BANK_W-1:0] ba;
   logic [ROW_W-1:0]  addr;
   logic              init_done, ref_req;

   int cyc = 0;
   int n_chk = 0;
   int n_bad = 0;

   sdram_pwrup_seq #(
      .CLK_KHZ (CLK_KHZ),
      .WAIT_US (WAIT_US)
   ) dut_i (
      .clk       (clk),
      .rst       (rst),
      .ref_ack   (ref_ack),
      .cke       (cke),
      .cs_n      (cs_n),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .we_n      (we_n),
      .ba        (ba),
      .addr      (addr),
      .init_done (init_done),
      .ref_req   (ref_req)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) begin
      if (rst) cyc <= 0;
      else     cyc <= cyc + 1;
   end

   function automatic logic [3:0] pins();
      return {cs_n, ras_n, cas_n, we_n};
   endfunction

   task automatic check(input bit ok, input string rq, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                  rq, what, cyc, act, exp);
      end
   endtask

   task automatic goto(input int c);
      while (cyc != c) @(negedge clk);
   endtask

   task automatic t_reset_state;
      repeat (2) @(negedge clk);
      check(cke == 1'b0,        "R1", "cke in reset",       cke, 0);
      check(pins() == P_NOP,    "R1", "pins in reset",      pins(), P_NOP);
      check(init_done == 1'b0,  "R1", "init_done in reset", init_done, 0);
      check(ref_req == 1'b0,    "R1", "ref_req in reset",   ref_req, 0);
      rst = 1'b0;
   endtask

   task automatic t_stabilise;
      for (int c = 1; c < W; c++) begin
         goto(c);
         ref_ack = (c >= 5 && c <= 15);   // R9: stray acknowledge during start-up
         check(cke == 1'b1,     "R2", "cke during wait",  cke, 1);
         check(pins() == P_NOP, "R2", "pins during wait", pins(), P_NOP);
         check(ref_req == 1'b0, "R9", "req during start-up ack", ref_req, 0);
      end
      ref_ack = 1'b0;
   endtask

   task automatic t_precharge;
      goto(W);
      check(pins() == P_PALL, "R3", "precharge pins", pins(), P_PALL);
      check(addr == 12'h400,  "R3", "precharge addr", addr, 12'h400);
      goto(W + 1);
      check(pins() == P_NOP,  "R3", "after precharge", pins(), P_NOP);
   endtask

   task automatic t_fast_refresh;
      int refs = 0;
      for (int c = W + 1; c < F0; c++) begin
         goto(c);
         check(pins() == P_NOP, "R4", "tRP gap", pins(), P_NOP);
      end
      for (int c = F0; c < F0 + FAST_HOLD; c++) begin
         logic [3:0] exp;
         goto(c);
         exp = (((c - F0 + 1) % FAST_IVL) == 0) ? P_AREF : P_NOP;
         if (pins() == P_AREF) refs++;
         check(pins() == exp, "R4", "fast phase pins", pins(), exp);
      end
      check(refs == FAST_HOLD / FAST_IVL, "R4", "refresh count",
            refs, FAST_HOLD / FAST_IVL);
      for (int c = F0 + FAST_HOLD; c < MODE_AT; c++) begin
         goto(c);
         check(pins() == P_NOP, "R5", "tRFC gap", pins(), P_NOP);
      end
   endtask

   task automatic t_mode;
      goto(MODE_AT);
      check(pins() == P_MODE,  "R5", "mode pins", pins(), P_MODE);
      check(addr == EXP_MODE,  "R5", "mode word", addr, EXP_MODE);
      check(ba == '0,          "R5", "mode bank", ba, 0);
      check(init_done == 1'b0, "R5", "done at mode write", init_done, 0);
   endtask

   task automatic t_done;
      goto(D - 1);
      check(init_done == 1'b0, "R6", "done before tMRD", init_done, 0);
      check(pins() == P_NOP,   "R6", "tMRD gap", pins(), P_NOP);
      for (int c = D; c < D + 50; c++) begin
         goto(c);
         check(init_done == 1'b1, "R6", "done held", init_done, 1);
         check(pins() == P_NOP,   "R6", "idle after done", pins(), P_NOP);
      end
   endtask

   task automatic t_request;
      goto(D + N - 1);
      check(ref_req == 1'b0, "R7", "req before interval", ref_req, 0);
      goto(D + N);
      check(ref_req == 1'b1, "R7", "req at interval", ref_req, 1);
      goto(D + N + 5);
      check(ref_req == 1'b1, "R7", "req held unacked", ref_req, 1);
      goto(D + N + 9);
      ref_ack = 1'b1;
      goto(D + N + 10);
      ref_ack = 1'b0;
      check(ref_req == 1'b0, "R7", "req after ack", ref_req, 0);
   endtask

   task automatic t_stray_ack;
      goto(D + N + 19);
      ref_ack = 1'b1;
      goto(D + N + 20);
      ref_ack = 1'b0;
      check(ref_req == 1'b0, "R9", "req after stray ack", ref_req, 0);
      goto(D + 2 * N - 1);
      check(ref_req == 1'b0, "R9", "req before 2nd interval", ref_req, 0);
      goto(D + 2 * N);
      check(ref_req == 1'b1, "R8", "2nd request on time", ref_req, 1);
   endtask

   task automatic t_periodic_race;
      goto(D + 2 * N + 2);
      ref_ack = 1'b1;
      goto(D + 2 * N + 3);
      ref_ack = 1'b0;
      check(ref_req == 1'b0, "R8", "2nd request cleared", ref_req, 0);
      goto(D + 3 * N - 1);
      check(ref_req == 1'b0, "R8", "before 3rd interval", ref_req, 0);
      ref_ack = 1'b1;
      goto(D + 3 * N);
      ref_ack = 1'b0;
      check(ref_req == 1'b1, "R8", "new interval beats ack", ref_req, 1);
      goto(D + 3 * N + 4);
      check(ref_req == 1'b1, "R8", "3rd request held", ref_req, 1);
   endtask

   initial begin
      t_reset_state();
      t_stabilise();
      t_precharge();
      t_fast_refresh();
      t_mode();
      t_done();
      t_request();
      t_stray_ack();
      t_periodic_race();
      repeat (3) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule